// File: doc/BRIEF.md
# Two-Way Registered Bus Transceiver

This block moves 18-bit words between an A side and a B side. Each of the two directions, A-to-B and B-to-A, has its own storage register and its own three controls: a latch enable, a direction clock and an output enable. When the latch enable is high the path is transparent and the destination output follows the source input combinationally. When the latch enable is low the stored word is held, and it is replaced only on a falling transition of that direction's clock. The two directions share no control and can run at the same time.

The block is synchronous to one system clock `clk`. The direction clocks are treated as data: each is sampled on every system clock edge, and a falling transition is recognised when it is seen high at one edge and low at the next. Each side is modelled as a separate input bus, output bus and output-enable flag in place of a tri-state pin. A synchronous reset clears both stores.

Top module: `bus_xcvr18`

## Requirements
- R1: After synchronous reset both stores hold zero, so with both latch enables low `bOut` and `aOut` read 0.
- R2: While `leAb` is high, `bOut` equals `aIn` in the same cycle, with no clock edge needed, and follows every change of `aIn`.
- R3: While `leAb` is low and no falling transition of `clkAb` is sampled, `bOut` keeps its value whatever `aIn` does.
- R4: With `leAb` low, at the first system clock edge where `clkAb` is sampled low after being sampled high, the value of `aIn` at that edge is stored and appears on `bOut` just after that edge.
- R5: When `leAb` goes low, `bOut` keeps the value `aIn` had at the last system clock edge at which `leAb` was high.
- R6: A falling transition of `clkAb` sampled while `leAb` is high has no effect beyond the transparent behaviour: after `leAb` drops, `bOut` holds the last transparent value.
- R7: A rising transition of `clkAb` never stores a new value.
- R8: `bOe` equals `oeAb` and `aOe` equals `oeBa`; each enable is active high.
- R9: The B-to-A path obeys R2 to R7 with `leBa`, `clkBa`, `bIn` and `aOut`, and neither path's controls or data affect the other path's store or output, including when both paths operate in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| aIn | input | 18 | Data arriving at the A side |
| aOut | output | 18 | Data driven onto the A side (B-to-A path) |
| aOe | output | 1 | A side drive enable |
| bIn | input | 18 | Data arriving at the B side |
| bOut | output | 18 | Data driven onto the B side (A-to-B path) |
| bOe | output | 1 | B side drive enable |
| leAb | input | 1 | A-to-B latch enable, high = transparent |
| clkAb | input | 1 | A-to-B direction clock, falling transition stores |
| oeAb | input | 1 | A-to-B output enable, active high |
| leBa | input | 1 | B-to-A latch enable, high = transparent |
| clkBa | input | 1 | B-to-A direction clock, falling transition stores |
| oeBa | input | 1 | B-to-A output enable, active high |

## Verification
The bench drops the latch enable while the input is still changing: a design that samples at the wrong edge returns the new word instead of the last transparent one. It holds the direction clock high across cycles, then raises it, so a design that stores on levels or on rising transitions shows a changed output. It lets the direction clock fall while the path is transparent, where a design that skips storing in that mode would return a stale word after the enable drops. It runs both paths in one cycle with different data, which exposes crossed indices or shared strobes.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int NUM_DIRS = 2;
  localparam int DIR_AB = 0;
  localparam int DIR_BA = 1;

  // Strobes from control to datapath, one bit per direction
  typedef struct packed {
    logic [NUM_DIRS-1:0] load;   // update store at this edge
    logic [NUM_DIRS-1:0] pass;   // route source straight to destination
  } xcvrStrobes_t;
endpackage

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl
  import xcvr_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_DIRS-1:0] latchEn,
  input  logic [NUM_DIRS-1:0] dirClk,
  output xcvrStrobes_t        strobes
);
  logic [NUM_DIRS-1:0] clkSeen;
  logic [NUM_DIRS-1:0] fallSeen;

  for (genvar d = 0; d < NUM_DIRS; d++) begin : gDir
    always_ff @(posedge clk) begin
      if (rst) clkSeen[d] <= 1'b0;
      else     clkSeen[d] <= dirClk[d];
    end

    assign fallSeen[d]     = clkSeen[d] & ~dirClk[d];
    assign strobes.pass[d] = latchEn[d];
    assign strobes.load[d] = latchEn[d] | fallSeen[d];

    // A rising transition alone never produces a load while latched
    AST_NO_LOAD_ON_RISE: assert property (@(posedge clk) disable iff (rst)
      (!latchEn[d] && dirClk[d]) |-> !strobes.load[d]); // R7
  end
endmodule

// File: rtl/xcvr_datapath.sv
module xcvr_datapath
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic                           clk,
  input  logic                           rst,
  input  xcvrStrobes_t                   strobes,
  input  logic [NUM_DIRS-1:0][WIDTH-1:0] srcData,
  output logic [NUM_DIRS-1:0][WIDTH-1:0] dstData
);
  logic [NUM_DIRS-1:0][WIDTH-1:0] store;

  for (genvar d = 0; d < NUM_DIRS; d++) begin : gPath
    always_ff @(posedge clk) begin
      if (rst)                  store[d] <= '0;
      else if (strobes.load[d]) store[d] <= srcData[d];
    end

    assign dstData[d] = strobes.pass[d] ? srcData[d] : store[d];

    AST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
      strobes.load[d] |=> (store[d] == $past(srcData[d]))); // R4
    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
      !strobes.load[d] |=> $stable(store[d])); // R3
  end
endmodule

// File: rtl/bus_xcvr18.sv
module bus_xcvr18
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] aIn,
  output logic [WIDTH-1:0] aOut,
  output logic             aOe,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] bOut,
  output logic             bOe,
  input  logic             leAb,
  input  logic             clkAb,
  input  logic             oeAb,
  input  logic             leBa,
  input  logic             clkBa,
  input  logic             oeBa
);
  xcvrStrobes_t                   strobes;
  logic [NUM_DIRS-1:0]            latchEn;
  logic [NUM_DIRS-1:0]            dirClk;
  logic [NUM_DIRS-1:0][WIDTH-1:0] srcData;
  logic [NUM_DIRS-1:0][WIDTH-1:0] dstData;

  assign latchEn[DIR_AB] = leAb;
  assign latchEn[DIR_BA] = leBa;
  assign dirClk[DIR_AB]  = clkAb;
  assign dirClk[DIR_BA]  = clkBa;
  assign srcData[DIR_AB] = aIn;
  assign srcData[DIR_BA] = bIn;

  xcvr_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .latchEn (latchEn),
    .dirClk  (dirClk),
    .strobes (strobes)
  );

  xcvr_datapath #(.WIDTH(WIDTH)) u_datapath (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .srcData (srcData),
    .dstData (dstData)
  );

  assign bOut = dstData[DIR_AB];
  assign aOut = dstData[DIR_BA];
  assign bOe  = oeAb;
  assign aOe  = oeBa;

  AST_AB_TRANSPARENT: assert property (@(posedge clk) disable iff (rst)
    leAb |-> (bOut == aIn)); // R2
  AST_BA_TRANSPARENT: assert property (@(posedge clk) disable iff (rst)
    leBa |-> (aOut == bIn)); // R9
endmodule

// File: tb/bus_xcvr18_bench.sv
module bus_xcvr18_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WIDTH = 18;
  localparam int WATCHDOG_CYCLES = 5000;

  logic             clk = 1'b0;
  logic             rst;
  logic [WIDTH-1:0] aIn, bIn, aOut, bOut;
  logic             aOe, bOe;
  logic             leAb, clkAb, oeAb, leBa, clkBa, oeBa;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_xcvr18 #(.WIDTH(WIDTH)) u_bus_xcvr18 (
    .clk(clk), .rst(rst),
    .aIn(aIn), .aOut(aOut), .aOe(aOe),
    .bIn(bIn), .bOut(bOut), .bOe(bOe),
    .leAb(leAb), .clkAb(clkAb), .oeAb(oeAb),
    .leBa(leBa), .clkBa(clkBa), .oeBa(oeBa)
  );

  task automatic check(input string req, input logic [WIDTH-1:0] act,
                       input logic [WIDTH-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // advance one system clock edge; inputs change 1 unit after the edge
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic testReset();
    rst = 1'b1;
    aIn = 18'h3FFFF; bIn = 18'h3FFFF;
    leAb = 0; clkAb = 0; oeAb = 0; leBa = 0; clkBa = 0; oeBa = 0;
    tick(); tick();
    rst = 1'b0;
    tick();
    check("R1 bOut after reset", bOut, '0);
    check("R1 aOut after reset", aOut, '0);
  endtask

  task automatic testTransparent();
    leAb = 1; aIn = 18'h15A5A; #1;
    check("R2 bOut follows aIn", bOut, 18'h15A5A);
    aIn = 18'h2C3C3; #1;
    check("R2 bOut follows change", bOut, 18'h2C3C3);
    leBa = 1; bIn = 18'h0F0F1; #1;
    check("R9 aOut follows bIn", aOut, 18'h0F0F1);
    tick();
    leAb = 0; leBa = 0;
  endtask

  task automatic testLeDropAndHold();
    clkAb = 1; leAb = 1; aIn = 18'h11111; tick();
    leAb = 0; aIn = 18'h22222; #1;
    check("R5 retains last transparent value", bOut, 18'h11111);
    tick();
    check("R5 retained after edge", bOut, 18'h11111);
    aIn = 18'h33333; tick(); tick();
    check("R3 held with clkAb steady high", bOut, 18'h11111);
    clkAb = 0; aIn = 18'h12345; tick();
    check("R4 store on falling clkAb", bOut, 18'h12345);
    aIn = 18'h0BEEF; tick(); tick();
    check("R3 held with clkAb steady low", bOut, 18'h12345);
    clkAb = 1; aIn = 18'h3ABCD; tick();
    check("R7 rising clkAb stores nothing", bOut, 18'h12345);
    clkAb = 0; aIn = 18'h2468A; tick();
    aIn = 18'h00001; #1;
    check("R4 second falling clkAb", bOut, 18'h2468A);
  endtask

  task automatic testFallWhileTransparent();
    clkAb = 1; leAb = 1; aIn = 18'h1C0DE; tick();
    clkAb = 0; tick();
    check("R6 transparent during fall", bOut, 18'h1C0DE);
    leAb = 0; aIn = 18'h00F00; #1;
    check("R6 no extra effect after drop", bOut, 18'h1C0DE);
    tick(); tick();
    check("R6 held after drop", bOut, 18'h1C0DE);
  endtask

  task automatic testEnables();
    oeAb = 0; oeBa = 0; #1;
    check("R8 bOe low", {17'd0, bOe}, 18'd0);
    check("R8 aOe low", {17'd0, aOe}, 18'd0);
    oeAb = 1; #1;
    check("R8 bOe high", {17'd0, bOe}, 18'd1);
    check("R8 aOe independent", {17'd0, aOe}, 18'd0);
    oeBa = 1; oeAb = 0; #1;
    check("R8 aOe high", {17'd0, aOe}, 18'd1);
    check("R8 bOe low again", {17'd0, bOe}, 18'd0);
  endtask

  task automatic testIndependent();
    // B-to-A stores while A-to-B stays latched with clkAb steady
    clkAb = 0; clkBa = 1; leAb = 0; leBa = 0; aIn = 18'h2AAAA; bIn = 18'h05555;
    tick();
    clkBa = 0; aIn = 18'h3F000; tick();
    check("R9 B-to-A stores on falling clkBa", aOut, 18'h05555);
    check("R9 A-to-B untouched", bOut, 18'h1C0DE);
    // both store in the same cycle with different data
    clkAb = 1; clkBa = 1; tick();
    clkAb = 0; clkBa = 0; aIn = 18'h13579; bIn = 18'h2468C; tick();
    check("R9 simultaneous A-to-B", bOut, 18'h13579);
    check("R9 simultaneous B-to-A", aOut, 18'h2468C);
    // A-to-B transparent while B-to-A holds
    leAb = 1; aIn = 18'h0ACE1; bIn = 18'h3FFFE; #1;
    check("R9 A-to-B transparent", bOut, 18'h0ACE1);
    check("R9 B-to-A holds meanwhile", aOut, 18'h2468C);
    tick();
    leAb = 0;
    // B-to-A rising edge and steady level keep value
    clkBa = 1; bIn = 18'h11223; tick(); tick();
    check("R9 B-to-A rise stores nothing", aOut, 18'h2468C);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    testReset();
    testTransparent();
    testLeDropAndHold();
    testFallWhileTransparent();
    testEnables();
    testIndependent();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule